// File: doc/BRIEF.md
# Staged Crosspoint Routing Register

This block holds the routing state of a 16-input, 8-output switch matrix. For every output it keeps a 4-bit source select and an enable flag. The state sits in two ranks. A staging rank collects new settings. A live rank drives the switch fabric. Settings enter the staging rank in one of two ways: one output at a time through an address/data write, or all at once as a 40-bit serial frame. They reach the live rank only while the update strobe is held low. Several outputs can therefore be staged and then switched in the same cycle.

The programming clock `prog_clk` is sampled in the system clock domain. Each falling edge of `prog_clk` is one load stroke. The synchronous reset clears every live enable and does not touch the staging rank, so a commit after reset can expose values left over from before it. The `load_primed` flag shows when the staging rank has been fully written since the last reset.

Top module: `xbar_route_reg`

## Requirements
- R1: With `cs_n` low, `ser_mode` high and `upd_n` high, a load stroke writes `data` into the staging entry picked by `addr` (0..7). `data[3:0]` is the source index 0..15 and `data[4]` is the enable (1 = driven). A disabled output shows `route_en` low whatever its select.
- R2: While `upd_n` is high, `route_sel` and `route_en` keep their values, including across load strokes.
- R3: While `cs_n` and `upd_n` are both low, the live rank copies the whole staging rank on the next clock. All outputs staged earlier change in the same cycle.
- R4: While the commit condition of R3 holds, later changes to the staging rank reach the outputs one clock after they land.
- R5: `rst` high clears every bit of `route_en` on the next clock, even when a commit is requested in the same cycle. The staging rank keeps its contents, so a later commit restores the values held before the reset.
- R6: With `cs_n` low and `ser_mode` low, each load stroke shifts `ser_in` into the staging rank. After 40 strokes the first bit shifted in is output 7's enable. Within each output the order is enable, then select bit 3 down to bit 0. Outputs follow from 7 down to 0.
- R7: While `cs_n` is high, load strokes change nothing and `upd_n` low does not commit.
- R8: A parallel-mode stroke with `upd_n` low leaves the staging rank unchanged.
- R9: `load_primed` is low after reset. It goes high once all eight addresses have been written in parallel mode, or once 40 serial strokes have been taken, since that reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset; disables live outputs |
| prog_clk | input | 1 | Programming clock; each falling edge is a load stroke |
| cs_n | input | 1 | Active-low chip select |
| ser_mode | input | 1 | 1 = address/data writes, 0 = serial shift |
| upd_n | input | 1 | Active-low transfer from staging to live rank |
| addr | input | 3 | Output index for parallel writes |
| data | input | 5 | Bit 4 enable, bits 3..0 source index |
| ser_in | input | 1 | Serial frame bit |
| route_sel | output | 32 | Live source select, 4 bits per output, output 0 in bits 3..0 |
| route_en | output | 8 | Live enable, one bit per output |
| load_primed | output | 1 | Staging rank fully written since reset |

## Verification
Staged parallel writes are followed by one commit. This separates a correct group commit from a design that applies writes at once or only partly. A serial frame built with a distinct select and enable for every output detects any change in shift direction, output order or bit order within an output. Strokes with chip select high, and parallel strokes with update low, are each followed by a commit that would expose any unwanted write. A reset followed by a bare commit shows whether the leftover staging contents survived. Shifting serially while update is held low separates the transparent transfer from an edge-triggered one.

// File: rtl/xbar_cfg_pkg.sv
package xbar_cfg_pkg;

    localparam int DEF_NUM_IN  = 16;
    localparam int DEF_NUM_OUT = 8;

    typedef enum logic [1:0] {
        LOAD_IDLE = 2'd0,
        LOAD_PAR  = 2'd1,
        LOAD_SER  = 2'd2
    } load_op_e;

    function automatic int entry_lsb(input int idx, input int ent_w);
        return idx * ent_w;
    endfunction

endpackage

// File: rtl/xbar_fall_detect.sv
module xbar_fall_detect (
    input  logic clk,
    input  logic rst,
    input  logic sig,
    output logic fall
);
    logic sig_q;

    always_ff @(posedge clk) begin
        if (rst) sig_q <= 1'b0;
        else     sig_q <= sig;
    end

    assign fall = sig_q & ~sig;
endmodule

// File: rtl/xbar_load_rank.sv
module xbar_load_rank
    import xbar_cfg_pkg::*;
#(
    parameter int NUM_OUT = DEF_NUM_OUT,
    parameter int ENT_W   = 5,
    parameter int ADDR_W  = 3
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       stroke,
    input  logic                       cs_n,
    input  logic                       ser_mode,
    input  logic                       upd_n,
    input  logic [ADDR_W-1:0]          addr,
    input  logic [ENT_W-1:0]           data,
    input  logic                       ser_in,
    output logic [NUM_OUT*ENT_W-1:0]   load_q,
    output logic                       primed
);
    localparam int FRAME_W = NUM_OUT * ENT_W;
    localparam int CNT_W   = $clog2(FRAME_W + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);

    load_op_e                op;
    logic [FRAME_W-1:0]      shifted;
    logic [NUM_OUT-1:0]      seen_q, seen_d;
    logic [CNT_W-1:0]        cnt_q, cnt_d;

    always_comb begin
        op = LOAD_IDLE;
        if (stroke && !cs_n) begin
            if (!ser_mode)  op = LOAD_SER;
            else if (upd_n) op = LOAD_PAR;
        end
    end

    assign shifted = {load_q[FRAME_W-2:0], ser_in};

    // Staging rank: deliberately not reset.
    always_ff @(posedge clk) begin
        if (op == LOAD_SER)
            load_q <= shifted;
        else if (op == LOAD_PAR)
            load_q[entry_lsb(int'(addr), ENT_W) +: ENT_W] <= data;
    end

    generate
        for (genvar g = 0; g < NUM_OUT; g++) begin : g_seen
            assign seen_d[g] = seen_q[g] | ((op == LOAD_PAR) && (addr == ADDR_W'(g)));
        end
    endgenerate

    assign cnt_d = ((op == LOAD_SER) && (cnt_q != CNT_FULL)) ? cnt_q + 1'b1 : cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_q <= '0;
            cnt_q  <= '0;
            primed <= 1'b0;
        end else begin
            seen_q <= seen_d;
            cnt_q  <= cnt_d;
            primed <= primed | (&seen_d) | (cnt_d == CNT_FULL);
        end
    end

    a_r7_cs_idle: assert property (@(posedge clk) disable iff (rst)
        cs_n |=> $stable(load_q));
    a_r5_reset_keeps_load: assert property (@(posedge clk)
        (rst && !stroke) |=> $stable(load_q));
    a_r8_par_blocked: assert property (@(posedge clk) disable iff (rst)
        (ser_mode && !upd_n) |=> $stable(load_q));
    a_r6_shift_in: assert property (@(posedge clk) disable iff (rst)
        (stroke && !cs_n && !ser_mode) |=> (load_q[0] == $past(ser_in)));
    a_r9_reset_unprimed: assert property (@(posedge clk)
        rst |=> !primed);
endmodule

// File: rtl/xbar_live_rank.sv
module xbar_live_rank
    import xbar_cfg_pkg::*;
#(
    parameter int NUM_OUT = DEF_NUM_OUT,
    parameter int SEL_W   = 4
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       commit,
    input  logic [NUM_OUT*(SEL_W+1)-1:0] load_q,
    output logic [NUM_OUT*SEL_W-1:0]   sel_o,
    output logic [NUM_OUT-1:0]         en_o
);
    localparam int ENT_W = SEL_W + 1;

    logic [NUM_OUT*SEL_W-1:0] stage_sel;
    logic [NUM_OUT-1:0]       stage_en;

    generate
        for (genvar g = 0; g < NUM_OUT; g++) begin : g_split
            assign stage_sel[g*SEL_W +: SEL_W] = load_q[g*ENT_W +: SEL_W];
            assign stage_en[g]                 = load_q[g*ENT_W + SEL_W];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (commit) sel_o <= stage_sel;
    end

    always_ff @(posedge clk) begin
        if (rst)         en_o <= '0;
        else if (commit) en_o <= stage_en;
    end

    a_r5_reset_disables: assert property (@(posedge clk)
        rst |=> (en_o == '0));
    a_r3_commit_copies: assert property (@(posedge clk) disable iff (rst)
        commit |=> (en_o == $past(stage_en)) && (sel_o == $past(stage_sel)));
    a_r2_hold: assert property (@(posedge clk) disable iff (rst)
        !commit |=> $stable(en_o) && $stable(sel_o));
endmodule

// File: rtl/xbar_route_reg.sv
module xbar_route_reg
    import xbar_cfg_pkg::*;
#(
    parameter int NUM_IN  = DEF_NUM_IN,
    parameter int NUM_OUT = DEF_NUM_OUT,
    localparam int SEL_W  = $clog2(NUM_IN),
    localparam int ENT_W  = SEL_W + 1,
    localparam int ADDR_W = $clog2(NUM_OUT)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     prog_clk,
    input  logic                     cs_n,
    input  logic                     ser_mode,
    input  logic                     upd_n,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [ENT_W-1:0]         data,
    input  logic                     ser_in,
    output logic [NUM_OUT*SEL_W-1:0] route_sel,
    output logic [NUM_OUT-1:0]       route_en,
    output logic                     load_primed
);
    logic                       stroke;
    logic                       commit;
    logic [NUM_OUT*ENT_W-1:0]   load_q;

    xbar_fall_detect u_fall (
        .clk  (clk),
        .rst  (rst),
        .sig  (prog_clk),
        .fall (stroke)
    );

    xbar_load_rank #(
        .NUM_OUT (NUM_OUT),
        .ENT_W   (ENT_W),
        .ADDR_W  (ADDR_W)
    ) u_load (
        .clk      (clk),
        .rst      (rst),
        .stroke   (stroke),
        .cs_n     (cs_n),
        .ser_mode (ser_mode),
        .upd_n    (upd_n),
        .addr     (addr),
        .data     (data),
        .ser_in   (ser_in),
        .load_q   (load_q),
        .primed   (load_primed)
    );

    assign commit = ~cs_n & ~upd_n;

    xbar_live_rank #(
        .NUM_OUT (NUM_OUT),
        .SEL_W   (SEL_W)
    ) u_live (
        .clk    (clk),
        .rst    (rst),
        .commit (commit),
        .load_q (load_q),
        .sel_o  (route_sel),
        .en_o   (route_en)
    );

    a_r7_no_commit_deselected: assert property (@(posedge clk) disable iff (rst)
        cs_n |=> $stable(route_en) && $stable(route_sel));
endmodule

// File: tb/xbar_route_reg_tb_top.sv
module xbar_route_reg_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        prog_clk = 1'b1;
    logic        cs_n = 1'b1;
    logic        ser_mode = 1'b1;
    logic        upd_n = 1'b1;
    logic [2:0]  addr = '0;
    logic [4:0]  data = '0;
    logic        ser_in = 1'b0;
    logic [31:0] route_sel;
    logic [7:0]  route_en;
    logic        load_primed;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [39:0] lr;
    logic [31:0] exp_sel;
    logic [7:0]  exp_en;

    always #10 clk = ~clk;

    xbar_route_reg dut_i (
        .clk(clk), .rst(rst), .prog_clk(prog_clk), .cs_n(cs_n),
        .ser_mode(ser_mode), .upd_n(upd_n), .addr(addr), .data(data),
        .ser_in(ser_in), .route_sel(route_sel), .route_en(route_en),
        .load_primed(load_primed)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic stroke();
        @(negedge clk) prog_clk = 1'b0;
        @(negedge clk) prog_clk = 1'b1;
        wait_n(1);
    endtask

    task automatic par_write(input logic [2:0] a, input logic [4:0] d);
        @(negedge clk);
        ser_mode = 1'b1; cs_n = 1'b0; addr = a; data = d;
        stroke();
    endtask

    task automatic ser_bit(input logic b);
        @(negedge clk);
        ser_mode = 1'b0; cs_n = 1'b0; ser_in = b;
        stroke();
    endtask

    task automatic do_commit();
        @(negedge clk) begin cs_n = 1'b0; upd_n = 1'b0; end
        wait_n(2);
        upd_n = 1'b1;
        wait_n(1);
    endtask

    task automatic do_reset();
        @(negedge clk) rst = 1'b1;
        @(negedge clk) rst = 1'b0;
        wait_n(1);
    endtask

    task automatic expect_from_stage();
        for (int k = 0; k < 8; k++) begin
            exp_en[k] = lr[k*5+4];
            exp_sel[k*4 +: 4] = lr[k*5 +: 4];
        end
    endtask

    task automatic check_live(input string tag);
        chk(route_en == exp_en, {tag, " en"}, 64'(route_en), 64'(exp_en));
        chk(route_sel == exp_sel, {tag, " sel"}, 64'(route_sel), 64'(exp_sel));
    endtask

    // R9 and R5: reset state
    task automatic t_reset_state();
        do_reset();
        chk(route_en == 8'h00, "R5 reset enables", 64'(route_en), 64'h0);
        chk(load_primed == 1'b0, "R9 unprimed after reset", 64'(load_primed), 64'h0);
    endtask

    // R1, R2, R3, R9: stage all outputs in parallel, then commit as a group
    task automatic t_parallel_group();
        for (int k = 0; k < 8; k++) begin
            logic [4:0] d;
            d = {1'b1, 4'(15 - 2*k)};
            if (k == 5) d = 5'b0_0110;  // disabled output (R1)
            par_write(3'(k), d);
            lr[k*5 +: 5] = d;
            if (k == 6)
                chk(load_primed == 1'b0, "R9 primed too early", 64'(load_primed), 64'h0);
        end
        chk(route_en == 8'h00, "R2 staged writes stay hidden", 64'(route_en), 64'h0);
        chk(load_primed == 1'b1, "R9 primed after 8 writes", 64'(load_primed), 64'h1);
        do_commit();
        expect_from_stage();
        check_live("R3 group commit");
        chk(route_en[5] == 1'b0, "R1 disabled output", 64'(route_en[5]), 64'h0);
    endtask

    // R1, R2: a single rewrite stays hidden until the next commit
    task automatic t_single_rewrite();
        par_write(3'd2, 5'b1_1010);
        lr[2*5 +: 5] = 5'b1_1010;
        check_live("R2 hold after single write");
        do_commit();
        expect_from_stage();
        check_live("R1 single rewrite committed");
    endtask

    // R7: chip select high blocks writes and commits
    task automatic t_deselected();
        @(negedge clk) begin cs_n = 1'b1; ser_mode = 1'b1; addr = 3'd0; data = 5'b1_0001; end
        @(negedge clk) prog_clk = 1'b0;
        @(negedge clk) prog_clk = 1'b1;
        @(negedge clk) upd_n = 1'b0;
        wait_n(2);
        check_live("R7 no commit while deselected");
        @(negedge clk) upd_n = 1'b1;
        do_commit();
        check_live("R7 write ignored while deselected");
    endtask

    // R8 and R4: parallel stroke with update low is ignored
    task automatic t_par_update_low();
        @(negedge clk) begin cs_n = 1'b0; upd_n = 1'b0; ser_mode = 1'b1; addr = 3'd4; data = 5'b1_0000; end
        @(negedge clk) prog_clk = 1'b0;
        @(negedge clk) prog_clk = 1'b1;
        wait_n(2);
        check_live("R8 parallel write with update low");
        upd_n = 1'b1;
        do_commit();
        check_live("R8 staging untouched after commit");
    endtask

    // R6, R9: full serial frame with a distinct value per output
    task automatic t_serial_frame();
        logic [39:0] frame;
        do_reset();
        for (int k = 0; k < 8; k++)
            frame[k*5 +: 5] = {(k != 3), 4'((5*k + 3) & 15)};
        for (int i = 0; i < 40; i++) begin
            int k = 7 - i/5;
            int b = 4 - i%5;
            ser_bit(frame[k*5 + b]);
            if (i == 38)
                chk(load_primed == 1'b0, "R9 primed before full frame", 64'(load_primed), 64'h0);
        end
        chk(load_primed == 1'b1, "R9 primed after frame", 64'(load_primed), 64'h1);
        lr = frame;
        do_commit();
        expect_from_stage();
        check_live("R6 serial frame order");
    endtask

    // R4: shifting while update is low passes straight through
    task automatic t_transparent();
        @(negedge clk) begin cs_n = 1'b0; upd_n = 1'b0; ser_mode = 1'b0; ser_in = 1'b1; end
        @(negedge clk) prog_clk = 1'b0;
        @(negedge clk) prog_clk = 1'b1;
        wait_n(1);
        lr = {lr[38:0], 1'b1};
        expect_from_stage();
        check_live("R4 transparent shift 1");
        @(negedge clk) ser_in = 1'b0;
        @(negedge clk) prog_clk = 1'b0;
        @(negedge clk) prog_clk = 1'b1;
        wait_n(1);
        lr = {lr[38:0], 1'b0};
        expect_from_stage();
        check_live("R4 transparent shift 2");
        upd_n = 1'b1;
        ser_mode = 1'b1;
        wait_n(1);
    endtask

    // R5: reset wins over commit and keeps leftover staging data
    task automatic t_reset_leftover();
        @(negedge clk) begin cs_n = 1'b0; upd_n = 1'b0; rst = 1'b1; end
        wait_n(1);
        chk(route_en == 8'h00, "R5 reset beats commit", 64'(route_en), 64'h0);
        @(negedge clk) begin rst = 1'b0; upd_n = 1'b1; end
        wait_n(1);
        chk(route_en == 8'h00, "R5 enables stay cleared", 64'(route_en), 64'h0);
        do_commit();
        expect_from_stage();
        check_live("R5 leftover staging restored");
    endtask

    initial begin
        wait_n(3);
        t_reset_state();
        t_parallel_group();
        t_single_rewrite();
        t_deselected();
        t_par_update_low();
        t_serial_frame();
        t_transparent();
        t_reset_leftover();
        wait_n(2);
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule